// File: doc/BRIEF.md
# Panel register-write SPI sequencer

This block sits between display-management logic and a small panel controller that is configured over a transmit-only serial link. It takes one request at a time on a valid/ready command port and turns it into a single 32-bit register write. The requests are: set contrast, set colour inversion, set orientation, power the panel up, and power it down. Every write leaves on a three-wire SPI master (clock, data out, select) running at one sixteenth of the system clock.

Power requests do more than a single write. They step the regulator enable, the panel enable line and the SPI interface gate in a fixed order around the display-on or display-off write. A programmable settle interval separates the rail steps. The block tracks whether the panel is powered. While the panel is off it drops appearance requests without sending anything. It also drops a request to enter the state the panel is already in.

When reset is released, the block treats the panel as already powered from boot. It opens the SPI interface and writes the default appearance: contrast 47, no inversion, normal orientation. Only then does it accept commands.

Top module: `panel_cfg_seq`

## Requirements
- R1: Every register write is one 32-bit frame, sent most significant bit first. Bits 31:24 are 0x00, bits 23:16 hold the register address, bits 15:8 are the constant 0x01 and bits 7:0 hold the value.
- R2: `spi_ss` is high for the whole frame and low between frames. `spi_sclk` idles high. `spi_mosi` changes only on a falling clock edge and is stable while the clock is high. Each frame has exactly 32 rising edges, one every CLK_DIV (16) system clocks. A frame is sent only while `spi_if_en` is high.
- R3: During reset `rail_en`, `panel_en` and `powered` are 1, `spi_if_en` is 0 and `cmd_ready` is 0. After reset, `spi_if_en` rises first. The block then sends the frames 0x000B012F, 0x00270100 and 0x00060104 in that order, and only after that raises `cmd_ready`.
- R4: Op 0 (contrast) writes register 0x0B. The value is `cmd_arg`, or 63 when `cmd_arg` is above 63.
- R5: Op 1 (invert) writes register 0x27. The value is 0x10 when `cmd_arg[0]` is 1 and 0x00 when it is 0.
- R6: Op 2 (flip) writes register 0x06. The value is 0x02 (upside-down) when `cmd_arg[0]` is 1 and 0x04 (normal) when it is 0.
- R7: Op 4 (power down) while powered runs these steps in this order: `powered` falls, frame 0x00040100 is sent, `spi_if_en` falls, `panel_en` falls, and finally `rail_en` falls.
- R8: Op 3 (power up) while unpowered runs these steps in this order: `rail_en` rises, `panel_en` rises, `spi_if_en` rises, frame 0x00040101 is sent, and finally `powered` rises.
- R9: While `powered` is 0, ops 0, 1 and 2 complete with no SPI frame. After a power-up, they write again.
- R10: Op 3 while powered and op 4 while unpowered complete with no SPI frame and leave `rail_en`, `panel_en`, `spi_if_en` and `powered` unchanged.
- R11: A request is accepted when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low and `busy` is high from acceptance until completion, and `cmd_ready` is never high while `spi_ss` is high. Each accepted request ends with a one-cycle `done` pulse.
- R12: Ops 5, 6 and 7 are accepted and complete with no SPI frame and no change to the power outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Block can accept a request |
| cmd_op | input | 3 | Request code: 0 contrast, 1 invert, 2 flip, 3 power up, 4 power down |
| cmd_arg | input | 8 | Request argument (contrast level or enable in bit 0) |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data out, MSB first |
| spi_ss | output | 1 | Slave select, active high |
| rail_en | output | 1 | Panel regulator enable |
| panel_en | output | 1 | Panel enable line |
| spi_if_en | output | 1 | SPI interface gate |
| powered | output | 1 | Panel is marked powered |
| busy | output | 1 | A request or the start-up sequence is in progress |
| done | output | 1 | One-cycle pulse when a request completes |

## Verification
The assertions assume that `cmd_op` and `cmd_arg` are stable in the cycle `cmd_valid` is sampled with `cmd_ready` high, and that reset is held for at least one clock. The bench drives the command inputs on falling clock edges. It raises `cmd_valid` only after it has seen `cmd_ready` high, and drops it one cycle later. Requests therefore never overlap, and a request is never withdrawn before it is accepted. A monitor rebuilds each frame from the SPI pins on rising serial-clock edges. It timestamps every edge of the power outputs, so the order of steps can be compared against the ordering requirements.

// File: rtl/panel_cfg_pkg.sv
package panel_cfg_pkg;

  localparam int FRAME_W = 32;

  localparam logic [2:0] OP_CONTRAST = 3'd0;
  localparam logic [2:0] OP_INVERT   = 3'd1;
  localparam logic [2:0] OP_FLIP     = 3'd2;
  localparam logic [2:0] OP_PWR_UP   = 3'd3;
  localparam logic [2:0] OP_PWR_DOWN = 3'd4;

  localparam logic [7:0] REG_CONTRAST = 8'h0B;
  localparam logic [7:0] REG_INVERT   = 8'h27;
  localparam logic [7:0] REG_FLIP     = 8'h06;
  localparam logic [7:0] REG_DISPLAY  = 8'h04;

  localparam logic [7:0] VAL_INV_ON    = 8'h10;
  localparam logic [7:0] VAL_INV_OFF   = 8'h00;
  localparam logic [7:0] VAL_FLIP_UP   = 8'h02;
  localparam logic [7:0] VAL_FLIP_NORM = 8'h04;
  localparam logic [7:0] VAL_DISP_ON   = 8'h01;
  localparam logic [7:0] VAL_DISP_OFF  = 8'h00;

  localparam logic [7:0] FRAME_LEAD   = 8'h00;
  localparam logic [7:0] FRAME_MARKER = 8'h01;

  typedef enum logic [4:0] {
    S_INIT_IF,
    S_INIT_CON,
    S_INIT_INV,
    S_INIT_FLP,
    S_IDLE,
    S_WRITE,
    S_PU_REG,
    S_PU_GPIO,
    S_PU_IF,
    S_PU_WR,
    S_PU_MARK,
    S_PD_CLR,
    S_PD_WR,
    S_PD_IF,
    S_PD_GPIO,
    S_PD_REG,
    S_FIN
  } seq_state_t;

  function automatic logic [FRAME_W-1:0] pack_frame(input logic [7:0] addr,
                                                    input logic [7:0] val);
    return {FRAME_LEAD, addr, FRAME_MARKER, val};
  endfunction

endpackage

// File: rtl/pcs_req_decode.sv
module pcs_req_decode
  import panel_cfg_pkg::*;
#(
  parameter int CONTRAST_MAX = 63
) (
  input  logic [2:0] op,
  input  logic [7:0] arg,
  output logic       is_write,
  output logic       is_pwr_up,
  output logic       is_pwr_dn,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_val
);
  localparam logic [7:0] CMAX = 8'(CONTRAST_MAX);

  always_comb begin
    is_write  = 1'b0;
    is_pwr_up = 1'b0;
    is_pwr_dn = 1'b0;
    wr_addr   = 8'h00;
    wr_val    = 8'h00;
    case (op)
      OP_CONTRAST: begin
        is_write = 1'b1;
        wr_addr  = REG_CONTRAST;
        wr_val   = (arg > CMAX) ? CMAX : arg;
      end
      OP_INVERT: begin
        is_write = 1'b1;
        wr_addr  = REG_INVERT;
        wr_val   = arg[0] ? VAL_INV_ON : VAL_INV_OFF;
      end
      OP_FLIP: begin
        is_write = 1'b1;
        wr_addr  = REG_FLIP;
        wr_val   = arg[0] ? VAL_FLIP_UP : VAL_FLIP_NORM;
      end
      OP_PWR_UP:   is_pwr_up = 1'b1;
      OP_PWR_DOWN: is_pwr_dn = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/pcs_spi_tx.sv
module pcs_spi_tx #(
  parameter int CLK_DIV = 16,
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               if_en,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic               sclk,
  output logic               mosi,
  output logic               ss,
  output logic               frame_done
);
  localparam int HALF   = CLK_DIV / 2;
  localparam int DIV_W  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int TICK_W = $clog2(2 * FRAME_W + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(HALF - 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(2 * FRAME_W);

  logic               active;
  logic [DIV_W-1:0]   div_cnt;
  logic [TICK_W-1:0]  tick;
  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      ss         <= 1'b0;
      sclk       <= 1'b1;
      mosi       <= 1'b0;
      div_cnt    <= '0;
      tick       <= '0;
      shreg      <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!active) begin
        sclk <= 1'b1;
        ss   <= 1'b0;
        if (start && if_en) begin
          active  <= 1'b1;
          ss      <= 1'b1;
          shreg   <= frame;
          div_cnt <= '0;
          tick    <= '0;
        end
      end else if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
        tick    <= tick + 1'b1;
        if (tick == TICK_LAST) begin
          active     <= 1'b0;
          ss         <= 1'b0;
          mosi       <= 1'b0;
          frame_done <= 1'b1;
        end else if (!tick[0]) begin
          sclk  <= 1'b0;
          mosi  <= shreg[FRAME_W-1];
          shreg <= {shreg[FRAME_W-2:0], 1'b0};
        end else begin
          sclk <= 1'b1;
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcs_seq_ctrl.sv
module pcs_seq_ctrl
  import panel_cfg_pkg::*;
#(
  parameter int SETTLE_CYC   = 4,
  parameter int DEF_CONTRAST = 47
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               dec_write,
  input  logic               dec_pwr_up,
  input  logic               dec_pwr_dn,
  input  logic [7:0]         dec_addr,
  input  logic [7:0]         dec_val,
  output logic               tx_start,
  output logic [FRAME_W-1:0] tx_frame,
  input  logic               tx_done,
  output logic               rail_en,
  output logic               panel_en,
  output logic               spi_if_en,
  output logic               powered,
  output logic               busy,
  output logic               done
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  seq_state_t         state, nxt;
  logic               tx_state, step_state, launched;
  logic [CNT_W-1:0]   wait_cnt;
  logic [7:0]         addr_q, val_q;
  logic [FRAME_W-1:0] frame_c;

  always_comb begin
    tx_state   = 1'b0;
    step_state = 1'b0;
    nxt        = state;
    frame_c    = pack_frame(addr_q, val_q);
    case (state)
      S_INIT_IF:  begin step_state = 1'b1; nxt = S_INIT_CON; end
      S_INIT_CON: begin
        tx_state = 1'b1; nxt = S_INIT_INV;
        frame_c  = pack_frame(REG_CONTRAST, 8'(DEF_CONTRAST));
      end
      S_INIT_INV: begin
        tx_state = 1'b1; nxt = S_INIT_FLP;
        frame_c  = pack_frame(REG_INVERT, VAL_INV_OFF);
      end
      S_INIT_FLP: begin
        tx_state = 1'b1; nxt = S_IDLE;
        frame_c  = pack_frame(REG_FLIP, VAL_FLIP_NORM);
      end
      S_WRITE:    begin tx_state = 1'b1; nxt = S_FIN; end
      S_PU_REG:   begin step_state = 1'b1; nxt = S_PU_GPIO; end
      S_PU_GPIO:  begin step_state = 1'b1; nxt = S_PU_IF; end
      S_PU_IF:    begin step_state = 1'b1; nxt = S_PU_WR; end
      S_PU_WR: begin
        tx_state = 1'b1; nxt = S_PU_MARK;
        frame_c  = pack_frame(REG_DISPLAY, VAL_DISP_ON);
      end
      S_PD_WR: begin
        tx_state = 1'b1; nxt = S_PD_IF;
        frame_c  = pack_frame(REG_DISPLAY, VAL_DISP_OFF);
      end
      S_PD_IF:    begin step_state = 1'b1; nxt = S_PD_GPIO; end
      S_PD_GPIO:  begin step_state = 1'b1; nxt = S_PD_REG; end
      S_PD_REG:   begin step_state = 1'b1; nxt = S_FIN; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_INIT_IF;
      launched  <= 1'b0;
      wait_cnt  <= '0;
      addr_q    <= 8'h00;
      val_q     <= 8'h00;
      tx_start  <= 1'b0;
      tx_frame  <= '0;
      rail_en   <= 1'b1;
      panel_en  <= 1'b1;
      spi_if_en <= 1'b0;
      powered   <= 1'b1;
      done      <= 1'b0;
    end else begin
      tx_start <= 1'b0;
      done     <= 1'b0;
      case (state)
        S_INIT_IF, S_PU_IF: spi_if_en <= 1'b1;
        S_PU_REG:  rail_en   <= 1'b1;
        S_PU_GPIO: panel_en  <= 1'b1;
        S_PD_IF:   spi_if_en <= 1'b0;
        S_PD_GPIO: panel_en  <= 1'b0;
        S_PD_REG:  rail_en   <= 1'b0;
        S_PU_MARK: begin powered <= 1'b1; state <= S_FIN; end
        S_PD_CLR:  begin powered <= 1'b0; state <= S_PD_WR; end
        S_FIN:     begin done <= 1'b1; state <= S_IDLE; end
        S_IDLE: begin
          if (cmd_valid) begin
            addr_q <= dec_addr;
            val_q  <= dec_val;
            if (dec_write)       state <= powered ? S_WRITE : S_FIN;
            else if (dec_pwr_up) state <= powered ? S_FIN : S_PU_REG;
            else if (dec_pwr_dn) state <= powered ? S_PD_CLR : S_FIN;
            else                 state <= S_FIN;
          end
        end
        default: ;
      endcase

      if (step_state) begin
        if (wait_cnt == CNT_LAST) begin
          wait_cnt <= '0;
          state    <= nxt;
        end else begin
          wait_cnt <= wait_cnt + 1'b1;
        end
      end

      if (tx_state) begin
        if (!launched) begin
          tx_start <= 1'b1;
          tx_frame <= frame_c;
          launched <= 1'b1;
        end else if (tx_done) begin
          launched <= 1'b0;
          state    <= nxt;
        end
      end
    end
  end

  assign cmd_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
endmodule

// File: rtl/panel_cfg_seq.sv
module panel_cfg_seq
  import panel_cfg_pkg::*;
#(
  parameter int CLK_DIV      = 16,
  parameter int SETTLE_CYC   = 4,
  parameter int DEF_CONTRAST = 47,
  parameter int CONTRAST_MAX = 63
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_arg,
  output logic       spi_sclk,
  output logic       spi_mosi,
  output logic       spi_ss,
  output logic       rail_en,
  output logic       panel_en,
  output logic       spi_if_en,
  output logic       powered,
  output logic       busy,
  output logic       done
);
  logic               dec_write, dec_pwr_up, dec_pwr_dn;
  logic [7:0]         dec_addr, dec_val;
  logic               tx_start, tx_done;
  logic [FRAME_W-1:0] tx_frame;

  pcs_req_decode #(.CONTRAST_MAX(CONTRAST_MAX)) u_dec (
    .op(cmd_op), .arg(cmd_arg),
    .is_write(dec_write), .is_pwr_up(dec_pwr_up), .is_pwr_dn(dec_pwr_dn),
    .wr_addr(dec_addr), .wr_val(dec_val)
  );

  pcs_seq_ctrl #(.SETTLE_CYC(SETTLE_CYC), .DEF_CONTRAST(DEF_CONTRAST)) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .dec_write(dec_write), .dec_pwr_up(dec_pwr_up), .dec_pwr_dn(dec_pwr_dn),
    .dec_addr(dec_addr), .dec_val(dec_val),
    .tx_start(tx_start), .tx_frame(tx_frame), .tx_done(tx_done),
    .rail_en(rail_en), .panel_en(panel_en), .spi_if_en(spi_if_en),
    .powered(powered), .busy(busy), .done(done)
  );

  pcs_spi_tx #(.CLK_DIV(CLK_DIV), .FRAME_W(FRAME_W)) u_spi (
    .clk(clk), .rst(rst), .if_en(spi_if_en),
    .start(tx_start), .frame(tx_frame),
    .sclk(spi_sclk), .mosi(spi_mosi), .ss(spi_ss), .frame_done(tx_done)
  );
endmodule

// File: rtl/panel_cfg_seq_chk.sv
module panel_cfg_seq_chk (
  input logic clk,
  input logic rst,
  input logic cmd_ready,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_ss,
  input logic rail_en,
  input logic panel_en,
  input logic spi_if_en,
  input logic powered,
  input logic done
);
  // R2
  ss_needs_if_chk: assert property (@(posedge clk) disable iff (rst)
    spi_ss |-> spi_if_en);
  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !spi_ss |-> spi_sclk);
  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_ss && $past(spi_ss) && !$stable(spi_mosi)) |-> $fell(spi_sclk));
  // R11
  no_ready_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    spi_ss |-> !cmd_ready);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7
  rail_last_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rail_en) |-> !panel_en);
  // R7
  panel_dn_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(panel_en) |-> (!spi_if_en && !powered));
  // R8
  if_up_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_if_en) |-> (panel_en && rail_en));
  // R8
  powered_up_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(powered) |-> spi_if_en);
endmodule

bind panel_cfg_seq panel_cfg_seq_chk u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready),
  .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_ss(spi_ss),
  .rail_en(rail_en), .panel_en(panel_en), .spi_if_en(spi_if_en),
  .powered(powered), .done(done)
);

// File: tb/tb_panel_cfg_seq.sv
module tb_panel_cfg_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_arg = 8'd0;
  logic cmd_ready, spi_sclk, spi_mosi, spi_ss;
  logic rail_en, panel_en, spi_if_en, powered, busy, done;

  panel_cfg_seq dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_ss(spi_ss),
    .rail_en(rail_en), .panel_en(panel_en), .spi_if_en(spi_if_en),
    .powered(powered), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // Monitor state
  int cyc = 0;
  logic prev_ss = 1'b0, prev_sclk = 1'b1, prev_mosi = 1'b0;
  logic prev_rail = 1'b1, prev_panel = 1'b1, prev_if = 1'b0, prev_pow = 1'b1;
  logic [31:0] sh = '0;
  int bits = 0, last_rise = -1;
  logic [31:0] frames [0:63];
  int frame_t [0:63];
  int nf = 0;
  int period_err = 0, bitcnt_err = 0, mosi_err = 0, idle_err = 0, ready_err = 0;
  int t_rail_up = -1, t_rail_dn = -1, t_panel_up = -1, t_panel_dn = -1;
  int t_if_up = -1, t_if_dn = -1, t_pow_up = -1, t_pow_dn = -1;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (spi_ss && !prev_ss) begin bits = 0; sh = '0; last_rise = -1; end
      if (spi_ss && spi_sclk && !prev_sclk) begin
        sh = {sh[30:0], spi_mosi};
        bits = bits + 1;
        if (last_rise >= 0 && (cyc - last_rise) != 16) period_err++;
        last_rise = cyc;
      end
      if (spi_ss && prev_ss && spi_sclk && prev_sclk && spi_mosi != prev_mosi) mosi_err++;
      if (!spi_ss && prev_ss) begin
        if (nf < 64) begin frames[nf] = sh; frame_t[nf] = cyc; end
        if (bits != 32) bitcnt_err++;
        nf++;
      end
      if (spi_ss && cmd_ready) ready_err++;
      if (!spi_ss && !spi_sclk) idle_err++;
      if (spi_ss && !spi_if_en) idle_err++;
      if (rail_en && !prev_rail) t_rail_up = cyc;
      if (!rail_en && prev_rail) t_rail_dn = cyc;
      if (panel_en && !prev_panel) t_panel_up = cyc;
      if (!panel_en && prev_panel) t_panel_dn = cyc;
      if (spi_if_en && !prev_if) t_if_up = cyc;
      if (!spi_if_en && prev_if) t_if_dn = cyc;
      if (powered && !prev_pow) t_pow_up = cyc;
      if (!powered && prev_pow) t_pow_dn = cyc;
    end
    prev_ss = spi_ss; prev_sclk = spi_sclk; prev_mosi = spi_mosi;
    prev_rail = rail_en; prev_panel = panel_en; prev_if = spi_if_en; prev_pow = powered;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Watchdog
  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  task automatic send(input logic [2:0] op, input logic [7:0] arg);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(!cmd_ready && busy, "R11", "ready low and busy after accept",
          {30'd0, cmd_ready, busy}, 32'h1);
    while (!done) @(negedge clk);
    @(negedge clk);
    check(!done, "R11", "done single pulse", {31'd0, done}, 32'h0);
  endtask

  function automatic logic [31:0] fr(input logic [7:0] a, input logic [7:0] v);
    return {8'h00, a, 8'h01, v};
  endfunction

  // {op, arg, has_frame, reg, value}
  localparam logic [27:0] VECS [0:12] = '{
    {3'd0, 8'h20, 1'b1, 8'h0B, 8'h20},
    {3'd0, 8'h3F, 1'b1, 8'h0B, 8'h3F},
    {3'd0, 8'h40, 1'b1, 8'h0B, 8'h3F},
    {3'd0, 8'hFF, 1'b1, 8'h0B, 8'h3F},
    {3'd0, 8'h00, 1'b1, 8'h0B, 8'h00},
    {3'd1, 8'h01, 1'b1, 8'h27, 8'h10},
    {3'd1, 8'h00, 1'b1, 8'h27, 8'h00},
    {3'd1, 8'hFE, 1'b1, 8'h27, 8'h00},
    {3'd2, 8'h01, 1'b1, 8'h06, 8'h02},
    {3'd2, 8'h00, 1'b1, 8'h06, 8'h04},
    {3'd5, 8'h12, 1'b0, 8'h00, 8'h00},
    {3'd7, 8'hFF, 1'b0, 8'h00, 8'h00},
    {3'd3, 8'h00, 1'b0, 8'h00, 8'h00}
  };

  initial begin
    int base;
    string tag;
    repeat (4) @(negedge clk);
    // R3 reset state
    check(rail_en && panel_en && powered && !spi_if_en && !cmd_ready && !spi_ss && spi_sclk,
          "R3", "reset outputs",
          {25'd0, rail_en, panel_en, powered, spi_if_en, cmd_ready, spi_ss, spi_sclk},
          32'h00000071);
    rst = 1'b0;
    @(negedge clk);
    check(!cmd_ready, "R3", "ready low during init", {31'd0, cmd_ready}, 32'h0);
    while (!cmd_ready) @(negedge clk);
    check(nf == 3, "R3", "init frame count", nf, 3);
    check(frames[0] == 32'h000B012F, "R3", "init contrast frame", frames[0], 32'h000B012F);
    check(frames[1] == 32'h00270100, "R3", "init invert frame", frames[1], 32'h00270100);
    check(frames[2] == 32'h00060104, "R3", "init flip frame", frames[2], 32'h00060104);
    check(t_if_up >= 0 && t_if_up < frame_t[0], "R3", "interface before first frame",
          t_if_up, frame_t[0]);

    foreach (VECS[i]) begin
      logic [2:0] op; logic [7:0] arg, ra, va; logic has;
      {op, arg, has, ra, va} = VECS[i];
      case (op)
        3'd0: tag = "R4";
        3'd1: tag = "R5";
        3'd2: tag = "R6";
        3'd3: tag = "R10";
        default: tag = "R12";
      endcase
      base = nf;
      send(op, arg);
      check(nf == base + (has ? 1 : 0), tag, "frame count", nf - base, has ? 1 : 0);
      if (has)
        check(frames[base] == fr(ra, va), {tag, " R1"}, "frame content", frames[base], fr(ra, va));
      else
        check(rail_en && panel_en && spi_if_en && powered, tag, "power outputs unchanged",
              {28'd0, rail_en, panel_en, spi_if_en, powered}, 32'hF);
    end

    // R7 power down
    base = nf;
    send(3'd4, 8'h00);
    check(nf == base + 1 && frames[base] == 32'h00040100, "R7", "display-off frame",
          frames[base], 32'h00040100);
    check(t_pow_dn < frame_t[base] && frame_t[base] < t_if_dn && t_if_dn < t_panel_dn &&
          t_panel_dn < t_rail_dn, "R7", "power-down order", t_if_dn, t_panel_dn);
    check(!rail_en && !panel_en && !spi_if_en && !powered, "R7", "outputs low",
          {28'd0, rail_en, panel_en, spi_if_en, powered}, 32'h0);

    // R9 appearance requests dropped while off
    base = nf;
    send(3'd0, 8'h10);
    send(3'd1, 8'h01);
    send(3'd2, 8'h01);
    check(nf == base, "R9", "no frames while off", nf - base, 0);

    // R10 power down while off ignored
    send(3'd4, 8'h00);
    check(nf == base && !rail_en && !panel_en && !spi_if_en && !powered, "R10",
          "second power-down ignored", {28'd0, rail_en, panel_en, spi_if_en, powered}, 32'h0);

    // R8 power up
    send(3'd3, 8'h00);
    check(nf == base + 1 && frames[base] == 32'h00040101, "R8", "display-on frame",
          frames[base], 32'h00040101);
    check(t_rail_up < t_panel_up && t_panel_up < t_if_up && t_if_up < frame_t[base] &&
          frame_t[base] < t_pow_up, "R8", "power-up order", t_if_up, frame_t[base]);
    check(rail_en && panel_en && spi_if_en && powered, "R8", "outputs high",
          {28'd0, rail_en, panel_en, spi_if_en, powered}, 32'hF);

    // R9 writes resume after power-up
    base = nf;
    send(3'd0, 8'h05);
    check(nf == base + 1 && frames[base] == 32'h000B0105, "R9", "contrast after power-up",
          frames[base], 32'h000B0105);

    // R2 / R11 monitor summaries
    check(period_err == 0, "R2", "sclk period", period_err, 0);
    check(bitcnt_err == 0, "R2", "32 bits per frame", bitcnt_err, 0);
    check(mosi_err == 0, "R2", "mosi stable while sclk high", mosi_err, 0);
    check(idle_err == 0, "R2", "sclk idle high and ss gated", idle_err, 0);
    check(ready_err == 0, "R11", "ready low during frame", ready_err, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule